// File: doc/BRIEF.md
# MII Receive Nibble Decoder

This block sits directly behind the 4-bit media-independent receive bus of an Ethernet PHY. On each receive clock edge it looks at the data-valid flag, the error flag and the data nibble. It sorts every cycle into one of five classes: idle, reserved, false carrier, good data or errored data. Frames are recognised from the data-valid window. The block discards the run of preamble nibbles, locks onto the start-of-frame delimiter and packs the payload nibbles into bytes. These bytes leave on a plain stream of valid, data, start-of-frame and end-of-frame.

Each output byte is held back until the next byte completes or data-valid drops. This lets the last byte carry the end-of-frame tag together with the frame-level error flags. A frame is marked errored when any errored-data cycle falls inside its data-valid window. An odd nibble left over at the end sets a separate alignment flag. A false-carrier indication seen between frames raises a one-cycle event. A frame whose data-valid window opens after the delimiter is discarded without output. At 100 Mb/s the receive clock is 25 MHz.

Top module: `mii_rx_decoder`

## Requirements
- R1: When data-valid and error are both low, the cycle is inter-frame for every data value (0x0 to 0xF). No byte is output and no false-carrier event is raised.
- R2: When data-valid is low and error is high, data 0x0 and the reserved codes 0x1 to 0xD and 0xF are treated as inter-frame. No byte is output and no false-carrier event is raised.
- R3: When data-valid is low, error is high and data is 0xE, the cycle is false carrier. A run of consecutive false-carrier cycles raises exactly one single-cycle `fc_event` pulse. A new pulse can only follow a cycle that is not false carrier.
- R4: A frame must open with one or more 0x5 nibbles followed by a 0xD nibble (the delimiter byte 0xD5). These nibbles are never output. The first payload byte after them is the only byte with `out_sof` high.
- R5: The payload is packed least-significant nibble first. The first nibble of each pair sets bits [3:0] of `out_data` and the second sets bits [7:4].
- R6: When data-valid falls, the last complete payload byte is the only byte of the frame with `out_eof` high. A frame with no complete payload byte produces no output.
- R7: `out_frame_err` is high together with `out_eof` if and only if at least one cycle of that frame's data-valid window, preamble included, had error high.
- R8: When a frame ends with an odd trailing nibble, that nibble is dropped and `out_align_err` is high together with `out_eof`. Otherwise `out_align_err` stays low.
- R9: When data-valid rises on a nibble other than 0x5, or a non-0x5 nibble other than 0xD interrupts the preamble, the whole frame is discarded with no output until data-valid falls.
- R10: After reset, every output is low.
- R11: `out_sof`, `out_eof`, `out_frame_err` and `out_align_err` are only ever high while `out_valid` is high. The two error flags are only high together with `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data-valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive data nibble |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Assembled payload byte |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| out_frame_err | output | 1 | Frame contained an errored-data cycle (with eof) |
| out_align_err | output | 1 | Frame ended on an odd nibble (with eof) |
| fc_event | output | 1 | One-cycle pulse per false-carrier run |

## Verification
A wrong nibble-phase bit shows up within the same frame. The payload bytes come out with their halves swapped or offset, or the frame ends with the alignment flag wrong. A delimiter or drop state that is stuck shows up as a whole frame lost or as spurious bytes, and it persists until data-valid falls. A sticky error bit that is not cleared, or a false-carrier history bit that is stale, is exposed at the end of the next frame or at the next false-carrier run. The bench therefore sweeps frame lengths, preamble lengths and error positions, plus every data code under each data-valid/error combination. It compares the full byte log of each frame with expected values it computes itself.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

   typedef enum logic [2:0] {
      CLS_IDLE = 3'd0,
      CLS_RSVD = 3'd1,
      CLS_FC   = 3'd2,
      CLS_DATA = 3'd3,
      CLS_DERR = 3'd4
   } cycle_cls_t;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_PRE  = 2'd1,
      FR_DATA = 2'd2,
      FR_DROP = 2'd3
   } frame_st_t;

endpackage

// File: rtl/mii_rx_classify.sv
module mii_rx_classify
   import mii_rx_pkg::*;
#(
   parameter int          NIB_W   = 4,
   parameter logic [3:0]  FC_CODE = 4'hE,
   parameter logic [3:0]  QUIET   = 4'h0
) (
   input  logic             dv,
   input  logic             er,
   input  logic [NIB_W-1:0] nib,
   output cycle_cls_t       cls
);

   initial begin
      if (NIB_W != 4) $error("mii_rx_classify: NIB_W must be 4");
   end

   always_comb begin
      if (dv) begin
         cls = er ? CLS_DERR : CLS_DATA;
      end else if (!er) begin
         cls = CLS_IDLE;
      end else if (nib == FC_CODE) begin
         cls = CLS_FC;
      end else if (nib == QUIET) begin
         cls = CLS_IDLE;
      end else begin
         cls = CLS_RSVD;
      end
   end

endmodule

// File: rtl/mii_rx_fc_detect.sv
module mii_rx_fc_detect
   import mii_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cycle_cls_t cls,
   output logic       fc_event
);

   logic is_fc;
   logic prev_fc_q;

   assign is_fc = (cls == CLS_FC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_fc_q <= 1'b0;
         fc_event  <= 1'b0;
      end else begin
         prev_fc_q <= is_fc;
         fc_event  <= is_fc & ~prev_fc_q;
      end
   end

   // R3: a run never yields two pulses back to back
   p_fc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fc_event |=> !fc_event);

   // R3: a pulse always follows a false-carrier cycle
   p_fc_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fc_event) |-> $past(cls) == CLS_FC);

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
   import mii_rx_pkg::*;
#(
   parameter int          NIB_W   = 4,
   parameter logic [3:0]  PRE_NIB = 4'h5,
   parameter logic [3:0]  SFD_HI  = 4'hD,
   localparam int         BYTE_W  = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cycle_cls_t        cls,
   input  logic [NIB_W-1:0]  nib,
   output logic              o_valid,
   output logic [BYTE_W-1:0] o_data,
   output logic              o_sof,
   output logic              o_eof,
   output logic              o_ferr,
   output logic              o_aerr
);

   initial begin
      if (PRE_NIB == SFD_HI) $error("mii_rx_framer: preamble and delimiter nibbles must differ");
   end

   frame_st_t         st_q;
   logic [NIB_W-1:0]  lo_q;
   logic              half_q;
   logic              pend_v_q;
   logic [BYTE_W-1:0] pend_b_q;
   logic              pend_sof_q;
   logic              first_q;
   logic              err_q;

   logic              in_dv;
   logic              in_err;
   logic [BYTE_W-1:0] new_byte;

   assign in_dv    = (cls == CLS_DATA) || (cls == CLS_DERR);
   assign in_err   = (cls == CLS_DERR);
   assign new_byte = {nib, lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= FR_IDLE;
         lo_q       <= '0;
         half_q     <= 1'b0;
         pend_v_q   <= 1'b0;
         pend_b_q   <= '0;
         pend_sof_q <= 1'b0;
         first_q    <= 1'b0;
         err_q      <= 1'b0;
         o_valid    <= 1'b0;
         o_data     <= '0;
         o_sof      <= 1'b0;
         o_eof      <= 1'b0;
         o_ferr     <= 1'b0;
         o_aerr     <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         o_sof   <= 1'b0;
         o_eof   <= 1'b0;
         o_ferr  <= 1'b0;
         o_aerr  <= 1'b0;
         unique case (st_q)
            FR_IDLE: begin
               if (in_dv) begin
                  err_q <= in_err;
                  st_q  <= (nib == PRE_NIB) ? FR_PRE : FR_DROP;
               end
            end
            FR_PRE: begin
               if (!in_dv) begin
                  st_q <= FR_IDLE;
               end else begin
                  err_q <= err_q | in_err;
                  if (nib == SFD_HI) begin
                     st_q     <= FR_DATA;
                     half_q   <= 1'b0;
                     first_q  <= 1'b1;
                     pend_v_q <= 1'b0;
                  end else if (nib != PRE_NIB) begin
                     st_q <= FR_DROP;
                  end
               end
            end
            FR_DATA: begin
               if (in_dv) begin
                  err_q <= err_q | in_err;
                  if (!half_q) begin
                     lo_q   <= nib;
                     half_q <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     if (pend_v_q) begin
                        o_valid <= 1'b1;
                        o_data  <= pend_b_q;
                        o_sof   <= pend_sof_q;
                     end
                     pend_v_q   <= 1'b1;
                     pend_b_q   <= new_byte;
                     pend_sof_q <= first_q;
                     first_q    <= 1'b0;
                  end
               end else begin
                  if (pend_v_q) begin
                     o_valid <= 1'b1;
                     o_data  <= pend_b_q;
                     o_sof   <= pend_sof_q;
                     o_eof   <= 1'b1;
                     o_ferr  <= err_q;
                     o_aerr  <= half_q;
                  end
                  pend_v_q <= 1'b0;
                  half_q   <= 1'b0;
                  st_q     <= FR_IDLE;
               end
            end
            FR_DROP: begin
               if (!in_dv) st_q <= FR_IDLE;
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   // R11: tags and flags only accompany a byte
   p_tags_need_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (o_sof | o_eof) |-> o_valid);
   p_flags_need_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (o_ferr | o_aerr) |-> o_eof);
   // R1: nothing leaves while the framer rests between frames
   p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_IDLE) |=> !o_valid);
   // R9: a discarded frame emits nothing
   p_drop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_DROP) |=> !o_valid);
   // R4: start-of-frame only after the delimiter was locked
   p_sof_after_sfd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      o_sof |-> $past(st_q) == FR_DATA);

endmodule

// File: rtl/mii_rx_decoder.sv
module mii_rx_decoder
   import mii_rx_pkg::*;
#(
   parameter int          NIB_W    = 4,
   parameter bit          IN_STAGE = 1'b1,
   parameter logic [3:0]  PRE_NIB  = 4'h5,
   parameter logic [3:0]  SFD_HI   = 4'hD,
   parameter logic [3:0]  FC_CODE  = 4'hE,
   localparam int         BYTE_W   = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_dv,
   input  logic              rx_er,
   input  logic [NIB_W-1:0]  rxd,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_frame_err,
   output logic              out_align_err,
   output logic              fc_event
);

   initial begin
      if (NIB_W != 4) $error("mii_rx_decoder: the bus is four bits wide");
   end

   logic             s_dv;
   logic             s_er;
   logic [NIB_W-1:0] s_nib;
   cycle_cls_t       cls;

   generate
      if (IN_STAGE) begin : g_in_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s_dv  <= 1'b0;
               s_er  <= 1'b0;
               s_nib <= '0;
            end else begin
               s_dv  <= rx_dv;
               s_er  <= rx_er;
               s_nib <= rxd;
            end
         end
      end else begin : g_in_wire
         assign s_dv  = rx_dv;
         assign s_er  = rx_er;
         assign s_nib = rxd;
      end
   endgenerate

   mii_rx_classify #(
      .NIB_W   (NIB_W),
      .FC_CODE (FC_CODE),
      .QUIET   (4'h0)
   ) u_cls (
      .dv  (s_dv),
      .er  (s_er),
      .nib (s_nib),
      .cls (cls)
   );

   mii_rx_fc_detect u_fc (
      .clk      (clk),
      .rst_n    (rst_n),
      .cls      (cls),
      .fc_event (fc_event)
   );

   mii_rx_framer #(
      .NIB_W   (NIB_W),
      .PRE_NIB (PRE_NIB),
      .SFD_HI  (SFD_HI)
   ) u_frm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls     (cls),
      .nib     (s_nib),
      .o_valid (out_valid),
      .o_data  (out_data),
      .o_sof   (out_sof),
      .o_eof   (out_eof),
      .o_ferr  (out_frame_err),
      .o_aerr  (out_align_err)
   );

   // R2: inter-frame error codes never produce a false-carrier pulse
   p_rsvd_no_fc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_RSVD) |=> !fc_event);

endmodule

// File: tb/test_mii_rx_decoder.sv
module test_mii_rx_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_dv = 1'b0;
   logic       rx_er = 1'b0;
   logic [3:0] rxd = 4'h0;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_sof;
   logic       out_eof;
   logic       out_frame_err;
   logic       out_align_err;
   logic       fc_event;

   always #2 clk = ~clk;

   mii_rx_decoder i_mii_rx_decoder (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_dv         (rx_dv),
      .rx_er         (rx_er),
      .rxd           (rxd),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_sof       (out_sof),
      .out_eof       (out_eof),
      .out_frame_err (out_frame_err),
      .out_align_err (out_align_err),
      .fc_event      (fc_event)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] lg_d   [0:63];
   logic       lg_sof [0:63];
   logic       lg_eof [0:63];
   logic       lg_fe  [0:63];
   logic       lg_ae  [0:63];
   int         lg_n = 0;
   int         fc_n = 0;
   logic [7:0] exp_b  [0:63];
   logic [3:0] seq    [0:159];

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && lg_n < 64) begin
            lg_d[lg_n]   = out_data;
            lg_sof[lg_n] = out_sof;
            lg_eof[lg_n] = out_eof;
            lg_fe[lg_n]  = out_frame_err;
            lg_ae[lg_n]  = out_align_err;
            lg_n++;
         end
         if (fc_event) fc_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic dv, input logic er, input logic [3:0] d);
      @(posedge clk);
      #1;
      rx_dv = dv;
      rx_er = er;
      rxd   = d;
   endtask

   task automatic settle();
      for (int i = 0; i < 6; i++) put(1'b0, 1'b0, 4'h0);
      @(negedge clk);
   endtask

   task automatic clear_log();
      lg_n = 0;
      fc_n = 0;
   endtask

   // drive seq[0..len-1] with data-valid high; err_at marks one errored nibble (-1: none)
   task automatic drive_seq(input int len, input int err_at);
      for (int i = 0; i < len; i++) put(1'b1, (i == err_at), seq[i]);
      put(1'b0, 1'b0, 4'h0);
   endtask

   // compare the log with exp_b[0..nb-1]
   task automatic compare(input int nb, input bit fe, input bit ae, input string tag);
      int bad_d = 0, bad_s = 0, bad_e = 0, bad_f = 0, bad_a = 0;
      chk(lg_n == nb, {"R6 byte count ", tag}, lg_n, nb);
      if (lg_n == nb) begin
         for (int i = 0; i < nb; i++) begin
            if (lg_d[i] !== exp_b[i]) bad_d++;
            if (lg_sof[i] !== (i == 0)) bad_s++;
            if (lg_eof[i] !== (i == nb - 1)) bad_e++;
            if (lg_fe[i] !== ((i == nb - 1) ? fe : 1'b0)) bad_f++;
            if (lg_ae[i] !== ((i == nb - 1) ? ae : 1'b0)) bad_a++;
         end
         if (nb > 0) begin
            chk(bad_d == 0, {"R5 byte values ", tag}, bad_d, 0);
            chk(bad_s == 0, {"R4 sof placement ", tag}, bad_s, 0);
            chk(bad_e == 0, {"R6 eof placement ", tag}, bad_e, 0);
            chk(bad_f == 0, {"R7 frame error flag ", tag}, bad_f, 0);
            chk(bad_a == 0, {"R8 alignment flag ", tag}, bad_a, 0);
         end
      end
   endtask

   // build preamble + delimiter + payload (+ optional odd nibble); returns length
   function automatic int build(input int pre, input int nb, input int seed, input bit odd);
      int k = 0;
      for (int i = 0; i < pre; i++) begin seq[k] = 4'h5; k++; end
      seq[k] = 4'hD; k++;
      for (int i = 0; i < nb; i++) begin
         exp_b[i] = 8'((seed * 37 + i * 11 + 3) & 8'hFF);
         seq[k] = exp_b[i][3:0]; k++;
         seq[k] = exp_b[i][7:4]; k++;
      end
      if (odd) begin seq[k] = 4'hA; k++; end
      return k;
   endfunction

   initial begin
      int len;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({out_valid, out_sof, out_eof, out_frame_err, out_align_err, fc_event} == 6'b0,
          "R10 outputs after reset",
          {out_valid, out_sof, out_eof, out_frame_err, out_align_err, fc_event}, 0);
      chk(out_data == 8'h00, "R10 data after reset", out_data, 0);

      // R1: idle with every data value
      clear_log();
      for (int c = 0; c < 16; c++) put(1'b0, 1'b0, 4'(c));
      settle();
      chk(lg_n == 0, "R1 idle codes give no bytes", lg_n, 0);
      chk(fc_n == 0, "R1 idle codes give no false carrier", fc_n, 0);

      // R2 / R3: every code with data-valid low, error high
      for (int c = 0; c < 16; c++) begin
         clear_log();
         for (int r = 0; r < 3; r++) put(1'b0, 1'b1, 4'(c));
         settle();
         chk(lg_n == 0, "R2 error-only codes give no bytes", lg_n, 0);
         if (c == 14) chk(fc_n == 1, "R3 false-carrier run counts once", fc_n, 1);
         else         chk(fc_n == 0, "R2 reserved code raises no event", fc_n, 0);
      end

      // R3: re-arm after a reserved cycle, and runs of different length
      clear_log();
      put(1'b0, 1'b1, 4'hE); put(1'b0, 1'b1, 4'hE);
      put(1'b0, 1'b1, 4'h3);
      put(1'b0, 1'b1, 4'hE);
      put(1'b0, 1'b0, 4'h0);
      for (int r = 0; r < 5; r++) put(1'b0, 1'b1, 4'hE);
      settle();
      chk(fc_n == 3, "R3 three separated runs", fc_n, 3);

      // R4 R5 R6: sweep lengths and preamble lengths
      for (int p = 1; p <= 7; p += 3) begin
         for (int nb = 1; nb <= 12; nb++) begin
            clear_log();
            len = build(p, nb, nb + p, 1'b0);
            drive_seq(len, -1);
            settle();
            compare(nb, 1'b0, 1'b0, "clean");
         end
      end

      // R7: error at every nibble position of a 5-byte frame with 3 preamble nibbles
      len = build(3, 5, 9, 1'b0);
      for (int e = 0; e < len; e++) begin
         clear_log();
         void'(build(3, 5, 9, 1'b0));
         drive_seq(len, e);
         settle();
         compare(5, 1'b1, 1'b0, "errored");
      end
      // R7: error flag is cleared for the next clean frame
      clear_log();
      len = build(2, 3, 4, 1'b0);
      drive_seq(len, -1);
      settle();
      compare(3, 1'b0, 1'b0, "clean after errored");

      // R8: odd trailing nibble
      for (int nb = 1; nb <= 4; nb++) begin
         clear_log();
         len = build(4, nb, 20 + nb, 1'b1);
         drive_seq(len, -1);
         settle();
         compare(nb, 1'b0, 1'b1, "odd tail");
      end

      // R6: zero-byte frame and single trailing nibble give no output
      clear_log();
      seq[0] = 4'h5; seq[1] = 4'hD;
      drive_seq(2, -1);
      seq[0] = 4'h5; seq[1] = 4'hD; seq[2] = 4'h7;
      drive_seq(3, -1);
      settle();
      chk(lg_n == 0, "R6 frame without whole byte is silent", lg_n, 0);

      // R9: late data-valid (starts inside payload), delimiter without preamble, broken preamble
      clear_log();
      len = build(4, 6, 31, 1'b0);
      for (int i = 0; i < len - 6; i++) seq[i] = seq[i + 6];
      drive_seq(len - 6, -1);
      seq[0] = 4'hD; seq[1] = 4'h1; seq[2] = 4'h2; seq[3] = 4'h3; seq[4] = 4'h4;
      drive_seq(5, -1);
      seq[0] = 4'h5; seq[1] = 4'h5; seq[2] = 4'h7; seq[3] = 4'hD; seq[4] = 4'h1; seq[5] = 4'h2;
      drive_seq(6, -1);
      settle();
      chk(lg_n == 0, "R9 late or malformed frames dropped", lg_n, 0);
      // R9: recovery after a dropped frame
      clear_log();
      len = build(1, 2, 40, 1'b0);
      drive_seq(len, -1);
      settle();
      compare(2, 1'b0, 1'b0, "after drop");

      // R3 with R6: false carrier directly after a frame ends it normally
      clear_log();
      len = build(2, 3, 50, 1'b0);
      for (int i = 0; i < len; i++) put(1'b1, 1'b0, seq[i]);
      put(1'b0, 1'b1, 4'hE); put(1'b0, 1'b1, 4'hE);
      settle();
      compare(3, 1'b0, 1'b0, "ended by false carrier");
      chk(fc_n == 1, "R3 false carrier after frame", fc_n, 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #600000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule